// File: doc/BRIEF.md
# UART Register Front End with Character FIFOs

This block is the register side of a serial port. A simple word-wide bus reads and writes five registers. Data written to the data register is queued in a transmit FIFO and handed to an external transmit shifter through a valid/ready handshake. Characters that an external receive shifter delivers are queued, together with their error flags, in a receive FIFO. Software takes them out of that FIFO by reading the data register.

Software first writes the control and line registers. It then polls the flag register before each transfer. It writes the data register only while the transmit FIFO is not full, and it reads the data register only while the receive FIFO is not empty. Each received character returns its own error flags above the low byte. A separate error register gathers every error seen since it was last cleared, and any write to that register clears it. The busy flag tells software when the last character has left the shifter, so the line settings can then be changed safely.

Word addresses on `bus_addr`: 0 data, 1 flags, 2 error status / clear, 3 line control, 4 control.

Top module: `uart_regif`

## Requirements
- R1: After reset the flag register reads 0x06. Its bits are: bit0 transmit FIFO full, bit1 receive FIFO empty, bit2 transmit FIFO empty, bit3 busy, bit4 receive FIFO full. After reset the control, line and error registers read 0.
- R2: A data-register write queues wdata[7:0]. Queued characters appear on `tx_data` in write order. They leave only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_valid` stays low unless control bit0 (enable) and bit1 (transmit enable) are both set.
- R3: The transmit FIFO reports full once it holds DEPTH characters. A data write made while it is full is dropped.
- R4: A data read removes the oldest received entry and returns it. Bits 7:0 hold the character, bit8 a framing error, bit9 a parity error and bit10 a break. A data read made while the receive FIFO is empty returns 0 and removes nothing.
- R5: A character that arrives while the receive FIFO is full is dropped. The next character that is stored carries bit11 (overrun) in its data word.
- R6: Reading address 2 returns the gathered error flags: bit0 framing, bit1 parity, bit2 break, bit3 overrun. A write of any value to address 2 clears them all.
- R7: Busy reads 1 while the transmit FIFO holds a character or `tx_shift_busy` is high, and reads 0 otherwise.
- R8: The control register holds bit0 enable, bit1 transmit enable, bit2 receive enable and bit3 RTS. Bit3 drives the `rts` pin. Writing 0 stops all traffic.
- R9: A received character is ignored, and leaves every flag unchanged, unless control bit0 and bit2 are both set.
- R10: The line register holds bits 1:0 word length (3 means 8 bits), which drive `line_wlen`, and bit2 FIFO enable. While FIFO enable is clear, each FIFO holds a single character.
- R11: Every read returns its data on `bus_rdata` one cycle after the request, with `bus_rvalid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Transmit character available |
| tx_data | output | 8 | Transmit character |
| tx_ready | input | 1 | Shifter takes the character |
| tx_shift_busy | input | 1 | Shifter is sending a character |
| rx_strobe | input | 1 | Received character present |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error on this character |
| rx_parity_err | input | 1 | Parity error on this character |
| rx_break | input | 1 | Break detected on this character |
| rts | output | 1 | Request-to-send output |
| line_wlen | output | 2 | Word-length setting for the shifters |

## Verification
The bench stalls the transmit shifter and fills the transmit FIFO to its limit, then writes one more character. A design that counted one entry too few or too many, or that accepted a write while full, would show a wrong full flag or send an extra character. It overflows the receive FIFO and then checks two things: that the dropped character is missing, and that the overrun mark lands on the next stored character and not on one already queued. It also checks that the error register clears only on a write to it. With FIFOs disabled it confirms that a single entry already reads as full. With receive or transmit disabled it confirms that traffic stops and that reading an empty FIFO returns zero.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int A_DATA  = 0;
  localparam int A_FLAGS = 1;
  localparam int A_ERR   = 2;
  localparam int A_LINE  = 3;
  localparam int A_CTRL  = 4;

  localparam int CHAR_W = 8;
  localparam int ERR_W  = 4;
  localparam int RXE_W  = CHAR_W + ERR_W;

  typedef struct packed {
    logic rts;
    logic rx_en;
    logic tx_en;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic       fifo_en;
    logic [1:0] wlen;
  } line_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         single,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic       wr_line,
  input  logic [3:0] wbits,
  output ctrl_t      ctrl_q,
  output line_t      line_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      line_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wbits);
      if (wr_line) line_q <= line_t'(wbits[2:0]);
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              tx_shift_busy,
  input  logic              rx_strobe,
  input  logic [7:0]        rx_char,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_break,
  output logic              rts,
  output logic [1:0]        line_wlen
);
  ctrl_t            ctrl_q;
  line_t            line_q;
  logic             wr_any, rd_any;
  logic             hit_data, hit_err, hit_line, hit_ctrl, hit_flags;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_acc, rx_push, rx_pop, rx_full, rx_empty, ovr_evt;
  logic             ovr_pend;
  logic [RXE_W-1:0] rx_entry, rx_head;
  logic [ERR_W-1:0] err_sticky, err_evt;
  logic             busy;

  assign wr_any    = bus_en && bus_we;
  assign rd_any    = bus_en && !bus_we;
  assign hit_data  = (bus_addr == ADDR_W'(A_DATA));
  assign hit_flags = (bus_addr == ADDR_W'(A_FLAGS));
  assign hit_err   = (bus_addr == ADDR_W'(A_ERR));
  assign hit_line  = (bus_addr == ADDR_W'(A_LINE));
  assign hit_ctrl  = (bus_addr == ADDR_W'(A_CTRL));

  uart_ctl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_any && hit_ctrl),
    .wr_line (wr_any && hit_line),
    .wbits   (bus_wdata[3:0]),
    .ctrl_q  (ctrl_q),
    .line_q  (line_q)
  );

  assign rts       = ctrl_q.rts;
  assign line_wlen = line_q.wlen;

  // transmit path
  assign tx_push  = wr_any && hit_data;
  assign tx_valid = !tx_empty && ctrl_q.en && ctrl_q.tx_en;
  assign tx_pop   = tx_valid && tx_ready;

  uart_fifo #(.W(CHAR_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk    (clk),
    .rst    (rst),
    .single (!line_q.fifo_en),
    .push   (tx_push),
    .din    (bus_wdata[CHAR_W-1:0]),
    .pop    (tx_pop),
    .dout   (tx_data),
    .full   (tx_full),
    .empty  (tx_empty)
  );

  assign busy = !tx_empty || tx_shift_busy;

  // receive path
  assign rx_acc   = rx_strobe && ctrl_q.en && ctrl_q.rx_en;
  assign rx_push  = rx_acc && !rx_full;
  assign ovr_evt  = rx_acc && rx_full;
  assign rx_pop   = rd_any && hit_data && !rx_empty;
  assign rx_entry = {ovr_pend, rx_break, rx_parity_err, rx_frame_err, rx_char};

  uart_fifo #(.W(RXE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk    (clk),
    .rst    (rst),
    .single (!line_q.fifo_en),
    .push   (rx_push),
    .din    (rx_entry),
    .pop    (rx_pop),
    .dout   (rx_head),
    .full   (rx_full),
    .empty  (rx_empty)
  );

  assign err_evt = {ovr_evt,
                    rx_push && rx_break,
                    rx_push && rx_parity_err,
                    rx_push && rx_frame_err};

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_pend   <= 1'b0;
      err_sticky <= '0;
    end else begin
      if (ovr_evt)      ovr_pend <= 1'b1;
      else if (rx_push) ovr_pend <= 1'b0;
      if (wr_any && hit_err) err_sticky <= err_evt;
      else                   err_sticky <= err_sticky | err_evt;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_any;
      if (rd_any) begin
        if (hit_data)       bus_rdata <= rx_empty ? '0 : {{(32-RXE_W){1'b0}}, rx_head};
        else if (hit_flags) bus_rdata <= {27'd0, rx_full, busy, tx_empty, rx_empty, tx_full};
        else if (hit_err)   bus_rdata <= {{(32-ERR_W){1'b0}}, err_sticky};
        else if (hit_line)  bus_rdata <= {29'd0, line_q};
        else if (hit_ctrl)  bus_rdata <= {28'd0, ctrl_q};
        else                bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_strobe,
  input logic              rts,
  input logic [3:0]        ctrl_bits,
  input logic              tx_full,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [3:0]        err_bits
);
  a_r2_tx_gated: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (ctrl_bits[0] && ctrl_bits[1]));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_full && bus_en && bus_we && bus_addr == ADDR_W'(A_DATA) && !(tx_valid && tx_ready))
    |=> tx_full);

  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && ctrl_bits[0] && ctrl_bits[2] && rx_full) |=> err_bits[3]);

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(A_ERR) && !rx_strobe) |=> (err_bits == 4'd0));

  a_r8_rts: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(A_CTRL)) |=> (rts == $past(bus_wdata[3])));

  a_r9_rx_ignored: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && !(ctrl_bits[0] && ctrl_bits[2]) && !(bus_en && !bus_we && bus_addr == ADDR_W'(A_DATA)))
    |=> (rx_empty == $past(rx_empty)));

  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we) |=> bus_rvalid);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_strobe  (rx_strobe),
  .rts        (rts),
  .ctrl_bits  (ctrl_q),
  .tx_full    (tx_full),
  .rx_full    (rx_full),
  .rx_empty   (rx_empty),
  .err_bits   (err_sticky)
);

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0, tx_shift_busy = 1'b0;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        rx_frame_err = 1'b0, rx_parity_err = 1'b0, rx_break = 1'b0;
  logic        rts;
  logic [1:0]  line_wlen;

  int checks = 0;
  int errors = 0;
  int tx_seen = 0;
  logic [7:0]  tx_exp[$];
  logic [31:0] rx_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_shift_busy(tx_shift_busy), .rx_strobe(rx_strobe), .rx_char(rx_char),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .rx_break(rx_break),
    .rts(rts), .line_wlen(line_wlen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  // driver side: queue the character the transmitter must emit
  task automatic send_tx(input logic [7:0] c, input bit expect_kept);
    wr(3'd0, {24'd0, c});
    if (expect_kept) tx_exp.push_back(c);
  endtask

  // driver side: present one received character, queue expected data word
  task automatic send_rx(input logic [7:0] c, input logic [2:0] e,
                         input bit kept, input bit ovr_mark);
    @(negedge clk);
    rx_strobe = 1'b1; rx_char = c;
    {rx_break, rx_parity_err, rx_frame_err} = e;
    @(negedge clk);
    rx_strobe = 1'b0; {rx_break, rx_parity_err, rx_frame_err} = 3'b000;
    if (kept) rx_exp.push_back({20'd0, ovr_mark, e, c});
  endtask

  task automatic pop_rx(input string req);
    logic [31:0] d;
    logic [31:0] e;
    rd(3'd0, d);
    e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 32'd0;
    chk(req, d, e);
  endtask

  // transmit monitor: a handshake seen now completes at the next rising edge
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      tx_seen++;
      if (tx_exp.size() == 0) chk("R2 unexpected tx char", {24'd0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 tx order", {24'd0, tx_data}, {24'd0, tx_exp.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(3'd1, d); chk("R1 reset flags", d, 32'h06);
    rd(3'd4, d); chk("R1 reset ctrl", d, 32'h0);
    rd(3'd3, d); chk("R1 reset line", d, 32'h0);
    rd(3'd2, d); chk("R1 reset err", d, 32'h0);

    wr(3'd4, 32'hF);
    chk("R8 rts high", {31'd0, rts}, 32'd1);
    wr(3'd3, 32'h7);
    rd(3'd3, d); chk("R10 line readback", d, 32'h7);
    chk("R10 wlen pin", {30'd0, line_wlen}, 32'd3);
    chk("R11 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    chk("R11 rvalid one cycle", {31'd0, bus_rvalid}, 32'd0);

    // fill transmit FIFO with shifter stalled
    for (int i = 0; i < DEPTH; i++) send_tx(8'(8'h20 + i), 1'b1);
    rd(3'd1, d); chk("R3 tx full flags", d, 32'h0B);
    send_tx(8'hEE, 1'b0);
    // transmit disabled: nothing may leave
    wr(3'd4, 32'hD);
    tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 tx gated by enable", tx_seen, 0);
    wr(3'd4, 32'hF);
    repeat (40) @(negedge clk);
    chk("R3 tx count", tx_seen, DEPTH);
    chk("R3 tx queue drained", tx_exp.size(), 0);
    rd(3'd1, d); chk("R7 idle flags", d, 32'h06);
    tx_shift_busy = 1'b1;
    rd(3'd1, d); chk("R7 shifter busy", d, 32'h0E);
    tx_shift_busy = 1'b0;

    // receive with per-character errors
    send_rx(8'h41, 3'b000, 1'b1, 1'b0);
    send_rx(8'h42, 3'b001, 1'b1, 1'b0);
    send_rx(8'h43, 3'b110, 1'b1, 1'b0);
    rd(3'd1, d); chk("R4 rx not empty", d, 32'h04);
    pop_rx("R4 plain char");
    pop_rx("R4 framing char");
    pop_rx("R4 parity break char");
    rd(3'd2, d); chk("R6 sticky errors", d, 32'h7);
    wr(3'd2, 32'h1234);
    rd(3'd2, d); chk("R6 cleared", d, 32'h0);
    rd(3'd0, d); chk("R4 empty read", d, 32'h0);

    // overrun
    for (int i = 0; i < DEPTH; i++) send_rx(8'(8'h60 + i), 3'b000, 1'b1, 1'b0);
    send_rx(8'h99, 3'b000, 1'b0, 1'b0);
    rd(3'd1, d); chk("R5 rx full flags", d, 32'h14);
    rd(3'd2, d); chk("R5 overrun sticky", d, 32'h8);
    for (int i = 0; i < DEPTH; i++) pop_rx("R5 stored chars");
    send_rx(8'h55, 3'b000, 1'b1, 1'b1);
    pop_rx("R5 overrun mark on next char");
    rd(3'd1, d); chk("R4 empty again", d, 32'h06);
    wr(3'd2, 32'h0);

    // single-entry mode
    wr(3'd3, 32'h3);
    send_rx(8'h61, 3'b000, 1'b1, 1'b0);
    send_rx(8'h62, 3'b000, 1'b0, 1'b0);
    rd(3'd1, d); chk("R10 single rx full", d, 32'h14);
    pop_rx("R10 single rx data");
    send_rx(8'h63, 3'b000, 1'b1, 1'b1);
    pop_rx("R10 single overrun mark");
    tx_ready = 1'b0;
    base = tx_seen;
    send_tx(8'h70, 1'b1);
    rd(3'd1, d); chk("R10 single tx full", d, 32'h0B);
    send_tx(8'h71, 1'b0);
    tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 single tx count", tx_seen - base, 1);
    wr(3'd3, 32'h7);
    wr(3'd2, 32'h0);

    // receiver disabled
    wr(3'd4, 32'hB);
    send_rx(8'h77, 3'b001, 1'b0, 1'b0);
    rd(3'd1, d); chk("R9 rx ignored flags", d, 32'h06);
    rd(3'd2, d); chk("R9 rx ignored err", d, 32'h0);

    // everything off
    wr(3'd4, 32'h0);
    chk("R8 rts low", {31'd0, rts}, 32'd0);
    base = tx_seen;
    send_tx(8'h7A, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 disabled no tx", tx_seen - base, 0);
    chk("R8 tx_valid low", {31'd0, tx_valid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule